// File: doc/BRIEF.md
# Three-Wide In-Order Dispatch Selector

This block sits between the bottom of an instruction queue and three issue queues. Each cycle it looks at the three oldest queue slots. Each slot carries a two-bit class tag. The tag sends the instruction to the general, floating-point or vector issue queue, or marks it as one that takes a completion-queue entry and nothing else. The block decides, purely combinationally, which of those slots leave the instruction queue this cycle.

The decision is strictly in order. A slot dispatches only when three things hold: it is valid, every older slot also dispatches, and room remains for it after the older slots have claimed theirs. Room means three things:
- a completion entry;
- a place under the overall per-cycle limit;
- a place under its issue queue's per-cycle acceptance cap and that queue's free-entry count.

The block reports the chosen slots, the destination of each one, and how many slots the instruction queue must shift out.

Top module: `dispatch_select`

## Requirements
- R1: A slot is enabled only if it is valid and every lower-numbered slot is enabled. An invalid slot blocks every slot above it.
- R2: No more than three slots are enabled in one cycle.
- R3: Per cycle, at most one class-01 (floating-point) slot, at most two class-10 (vector) slots and at most three class-00 (general) slots are enabled.
- R4: Enabled slots of class 00, 01 and 10 never exceed the free-entry count of the general, floating-point and vector issue queue respectively. Older slots claim entries first.
- R5: The total number of enabled slots never exceeds the completion-queue free count. This includes class-11 (completion-only) slots, which need no issue-queue entry.
- R6: A slot is enabled whenever all of the following hold:
  - it is valid;
  - all slots below it are enabled;
  - a completion entry, a place under the overall limit, and a place in its class's cap and issue-queue free count remain after the older slots' claims.
- R7: `disp_count` equals the number of enabled slots. Because of R1 these are always the lowest ones.
- R8: Field k of `disp_dest` (bits 2k+1:2k) equals slot k's class when slot k is enabled, and 00 when it is not.
- R9: With every slot invalid, no slot is enabled and `disp_count` is 0, whatever the free counts are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_valid | input | 3 | Valid bit per candidate slot, bit 0 oldest |
| slot_class | input | 6 | Two-bit class per slot: 00 general, 01 floating-point, 10 vector, 11 completion-only |
| gen_free | input | 5 | Free entries in the general issue queue |
| fp_free | input | 5 | Free entries in the floating-point issue queue |
| vec_free | input | 5 | Free entries in the vector issue queue |
| cq_free | input | 5 | Free entries in the completion queue |
| disp_en | output | 3 | Per-slot dispatch enable |
| disp_dest | output | 6 | Destination class of each enabled slot, 00 when not enabled |
| disp_count | output | 2 | Number of slots dispatched, used to shift the queue |

## Verification
The bench builds the block with its defaults: three candidate slots, a total limit of three, caps of one, two and three, and 5-bit free counts. With 5-bit counts, a free count can sit well above a queue's cap, so the cap is the limit that binds. It can also sit at zero or one, so the free count is the limit that binds. The random free counts are mostly drawn from 0 to 3, which keeps both kinds of limit and the completion limit in play with every class mix. Directed vectors pin the single floating-point acceptance, the vector cap of two and the completion-only slot blocked by a full completion queue.

// File: rtl/dispatch_select.sv
module dispatch_select #(
  parameter int SLOTS    = 3,
  parameter int DISP_MAX = 3,
  parameter int GEN_CAP  = 3,
  parameter int FP_CAP   = 1,
  parameter int VEC_CAP  = 2,
  parameter int FREE_W   = 5,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]   slot_valid,
  input  logic [2*SLOTS-1:0] slot_class,
  input  logic [FREE_W-1:0]  gen_free,
  input  logic [FREE_W-1:0]  fp_free,
  input  logic [FREE_W-1:0]  vec_free,
  input  logic [FREE_W-1:0]  cq_free,
  output logic [SLOTS-1:0]   disp_en,
  output logic [2*SLOTS-1:0] disp_dest,
  output logic [CNT_W-1:0]   disp_count
);

  localparam int AW = FREE_W + 1;
  localparam logic [AW-1:0] ONE     = AW'(1);
  localparam logic [AW-1:0] LIM_ALL = AW'(DISP_MAX);
  localparam logic [AW-1:0] LIM_GEN = AW'(GEN_CAP);
  localparam logic [AW-1:0] LIM_FP  = AW'(FP_CAP);
  localparam logic [AW-1:0] LIM_VEC = AW'(VEC_CAP);

  logic [AW-1:0] n_all, n_gen, n_fp, n_vec;
  logic          go, room;
  logic [1:0]    cls;

  always_comb begin
    n_all = '0; n_gen = '0; n_fp = '0; n_vec = '0;
    go = 1'b1; room = 1'b0; cls = 2'b00;
    disp_en = '0;
    disp_dest = '0;
    for (int k = 0; k < SLOTS; k++) begin
      cls = slot_class[2*k +: 2];
      case (cls)
        2'b00:   room = (n_gen < LIM_GEN) && (n_gen < {1'b0, gen_free});
        2'b01:   room = (n_fp  < LIM_FP)  && (n_fp  < {1'b0, fp_free});
        2'b10:   room = (n_vec < LIM_VEC) && (n_vec < {1'b0, vec_free});
        default: room = 1'b1;
      endcase
      go = go && slot_valid[k] && room &&
           (n_all < {1'b0, cq_free}) && (n_all < LIM_ALL);
      disp_en[k] = go;
      if (go) begin
        disp_dest[2*k +: 2] = cls;
        n_all = n_all + ONE;
        case (cls)
          2'b00:   n_gen = n_gen + ONE;
          2'b01:   n_fp  = n_fp  + ONE;
          2'b10:   n_vec = n_vec + ONE;
          default: ;
        endcase
      end
    end
  end

  assign disp_count = n_all[CNT_W-1:0];

endmodule

// File: rtl/dispatch_select_chk.sv
module dispatch_select_chk #(
  parameter int SLOTS    = 3,
  parameter int DISP_MAX = 3,
  parameter int GEN_CAP  = 3,
  parameter int FP_CAP   = 1,
  parameter int VEC_CAP  = 2,
  parameter int FREE_W   = 5,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input logic [SLOTS-1:0]   slot_valid,
  input logic [2*SLOTS-1:0] slot_class,
  input logic [FREE_W-1:0]  gen_free,
  input logic [FREE_W-1:0]  fp_free,
  input logic [FREE_W-1:0]  vec_free,
  input logic [FREE_W-1:0]  cq_free,
  input logic [SLOTS-1:0]   disp_en,
  input logic [2*SLOTS-1:0] disp_dest,
  input logic [CNT_W-1:0]   disp_count
);

  int ng, nf, nv, nt;

  always_comb begin
    ng = 0; nf = 0; nv = 0; nt = 0;
    for (int k = 0; k < SLOTS; k++) begin
      if (disp_en[k]) begin
        nt = nt + 1;
        if (slot_class[2*k +: 2] == 2'b00) ng = ng + 1;
        if (slot_class[2*k +: 2] == 2'b01) nf = nf + 1;
        if (slot_class[2*k +: 2] == 2'b10) nv = nv + 1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      p_valid_only_r1: assert (!disp_en[k] || slot_valid[k]);
      if (k > 0) begin
        p_in_order_r1: assert (!disp_en[k] || disp_en[k-1]);
      end
      p_dest_idle_r8: assert (disp_en[k] || disp_dest[2*k +: 2] == 2'b00);
    end
    p_total_cap_r2: assert (nt <= DISP_MAX);
    p_class_cap_r3: assert (ng <= GEN_CAP && nf <= FP_CAP && nv <= VEC_CAP);
    p_iq_free_r4: assert (ng <= int'(gen_free) && nf <= int'(fp_free) && nv <= int'(vec_free));
    p_cq_free_r5: assert (nt <= int'(cq_free));
    p_count_r7: assert (int'(disp_count) == $countones(disp_en));
    p_idle_r9: assert (slot_valid != '0 || disp_en == '0);
  end

endmodule

bind dispatch_select dispatch_select_chk #(
  .SLOTS(SLOTS), .DISP_MAX(DISP_MAX), .GEN_CAP(GEN_CAP),
  .FP_CAP(FP_CAP), .VEC_CAP(VEC_CAP), .FREE_W(FREE_W)
) u_chk (
  .slot_valid(slot_valid), .slot_class(slot_class),
  .gen_free(gen_free), .fp_free(fp_free), .vec_free(vec_free),
  .cq_free(cq_free), .disp_en(disp_en), .disp_dest(disp_dest),
  .disp_count(disp_count)
);

// File: tb/tb_dispatch_select.sv
`timescale 1ns/1ps
module tb_dispatch_select;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] slot_valid;
  logic [5:0] slot_class;
  logic [4:0] gen_free, fp_free, vec_free, cq_free;
  logic [2:0] disp_en;
  logic [5:0] disp_dest;
  logic [1:0] disp_count;

  int vectors = 0;
  int fails = 0;

  dispatch_select dut (
    .slot_valid(slot_valid), .slot_class(slot_class),
    .gen_free(gen_free), .fp_free(fp_free), .vec_free(vec_free),
    .cq_free(cq_free), .disp_en(disp_en), .disp_dest(disp_dest),
    .disp_count(disp_count)
  );

  function automatic logic [2:0] exp_en(logic [2:0] v, logic [5:0] c,
      int g, int f, int vq, int cq);
    int ug = 0, uf = 0, uv = 0, ut = 0;
    logic [2:0] e = '0;
    for (int k = 0; k < 3; k++) begin
      logic [1:0] t = c[2*k +: 2];
      bit ok = v[k] && ut < 3 && ut < cq;
      if (t == 2'b00) ok = ok && ug < 3 && ug < g;
      if (t == 2'b01) ok = ok && uf < 1 && uf < f;
      if (t == 2'b10) ok = ok && uv < 2 && uv < vq;
      if (!ok) break;
      e[k] = 1'b1;
      ut++;
      if (t == 2'b00) ug++;
      if (t == 2'b01) uf++;
      if (t == 2'b10) uv++;
    end
    return e;
  endfunction

  task automatic apply(string tag, logic [2:0] v, logic [5:0] c,
      int g, int f, int vq, int cq);
    logic [2:0] e;
    logic [5:0] d;
    logic [1:0] n;
    @(negedge clk);
    slot_valid = v; slot_class = c;
    gen_free = 5'(g); fp_free = 5'(f); vec_free = 5'(vq); cq_free = 5'(cq);
    #1;
    e = exp_en(v, c, g, f, vq, cq);
    d = '0; n = '0;
    for (int k = 0; k < 3; k++)
      if (e[k]) begin
        d[2*k +: 2] = c[2*k +: 2];
        n = n + 2'd1;
      end
    vectors++;
    if (disp_en !== e) begin
      fails++;
      $display("FAIL %s R6 disp_en actual=%b expected=%b", tag, disp_en, e);
    end
    if (disp_dest !== d) begin
      fails++;
      $display("FAIL %s R8 disp_dest actual=%b expected=%b", tag, disp_dest, d);
    end
    if (disp_count !== n) begin
      fails++;
      $display("FAIL %s R7 disp_count actual=%0d expected=%0d", tag, disp_count, n);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    apply("R9 all invalid", 3'b000, 6'b000000, 9, 9, 9, 9);
    apply("R9 invalid free zero", 3'b000, 6'b110110, 0, 0, 0, 0);
    apply("R3 two fp one cap", 3'b111, 6'b000101, 5, 5, 5, 5);
    apply("R3 three vec cap two", 3'b111, 6'b101010, 5, 5, 5, 5);
    apply("R3 three gen", 3'b111, 6'b000000, 5, 5, 5, 5);
    apply("R4 gen free two", 3'b111, 6'b000000, 2, 5, 5, 5);
    apply("R4 vec free zero", 3'b111, 6'b001000, 5, 5, 0, 5);
    apply("R5 cq zero compl only", 3'b111, 6'b111111, 5, 5, 5, 0);
    apply("R5 cq one", 3'b111, 6'b111111, 5, 5, 5, 1);
    apply("R5 compl only three", 3'b111, 6'b111111, 0, 0, 0, 3);
    apply("R1 hole at slot1", 3'b101, 6'b000000, 5, 5, 5, 5);
    apply("R1 slot0 invalid", 3'b110, 6'b000000, 5, 5, 5, 5);
    apply("R2 mixed four free", 3'b111, 6'b111001, 5, 5, 5, 9);
    apply("R6 fp blocks younger", 3'b111, 6'b000001, 5, 0, 5, 5);
    for (int i = 0; i < 3000; i++) begin
      int g, f, vq, cq;
      if (($urandom % 4) == 0) begin
        g = $urandom % 32; f = $urandom % 32;
        vq = $urandom % 32; cq = $urandom % 32;
      end else begin
        g = $urandom % 4; f = $urandom % 4;
        vq = $urandom % 4; cq = $urandom % 4;
      end
      apply("R6 random", 3'($urandom), 6'($urandom), g, f, vq, cq);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule